// File: doc/BRIEF.md
# DSP Address Generation Unit

This block produces data-memory addresses for register-indirect loads and stores on a signal processor. It keeps a small bank of pointer registers. Each pointer has a step register and a modifier register beside it, and the block also holds one dedicated stack pointer. Several address lanes work side by side, two by default. Each lane can accept one request per cycle. A request names a pointer and an addressing mode and says whether the pointer is written back. The lane emits the address that the pointer held before the access. On the same clock edge it stores the post-modified pointer.

The post-update can follow one of several rules:

- a plain two's-complement add of the step;
- a circular-buffer wrap whose length comes from the modifier;
- a reverse-carry add that walks an array in FFT bit-reversed order;
- a push or pop on the stack pointer.

Pointers, steps, modifiers and the stack pointer are loaded through a plain configuration write port. Requests enter each lane through a valid/ready handshake. The lane's addresses leave through a registered valid/ready output stage, so a stalled consumer holds the address and stops new requests on that lane.

Top module: `dsp_agu`

## Requirements
- R1: After reset, every lane shows `req_ready` high and `addr_valid` low, and the stack pointer holds `SP_INIT`. A first push therefore emits `SP_INIT-1`.
- R2: Mode code 0 (linear), and codes 5 to 7, emit the current pointer value. When `req_upd` is set, the pointer is replaced by pointer plus step, with the step taken as two's complement and the sum taken modulo 2^AW.
- R3: In modes 0, 1 and 2, a request with `req_upd` low leaves the pointer unchanged, so the next access emits the same address.
- R4: Mode code 1 (circular) sets up a buffer whose length M is the modifier value and whose size P is the smallest power of two that is not below M. The buffer base is the pointer with its low log2(P) bits cleared. The pointer becomes base + ((pointer − base + step) mod M), for steps with |step| ≤ M. A modifier of 0 makes mode 1 act as linear.
- R5: Mode code 2 (reverse-carry) computes the new pointer by adding the step with carries running from the most significant bit toward the least significant bit. A carry out of bit 0 is dropped. With a base aligned to N words and a step of N/2, successive addresses visit the N entries in bit-reversed order.
- R6: Mode code 3 (push) emits SP−1 and leaves SP−1 in the stack pointer. Mode code 4 (pop) emits SP and leaves SP+1 in the stack pointer. Both modes move the stack pointer whatever `req_upd` is.
- R7: All lanes accept requests in the same cycle. Each lane reads the register values as they stood before that cycle's write-back.
- R8: When several lanes write the same pointer, or the stack pointer, in one cycle, the lowest-numbered lane's value is kept.
- R9: `req_ready` of a lane is high exactly when its output stage is empty or `addr_ready` is high. While `addr_valid` is high and `addr_ready` is low, `addr_data` stays unchanged. A request, and its register update, takes effect only on a cycle where `req_valid` and `req_ready` are both high.
- R10: A write with `cfg_we` high stores `cfg_data` into the register that `cfg_file` selects: 0 selects a pointer, 1 a step, 2 a modifier and 3 the stack pointer. `cfg_idx` picks the entry. A configuration write overrides a lane update of the same register in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_file | input | 2 | Register group: 0 pointer, 1 step, 2 modifier, 3 stack pointer |
| cfg_idx | input | IW | Entry index for the configuration write |
| cfg_data | input | AW | Configuration write value |
| req_valid | input | NU | Per-lane request valid |
| req_ready | output | NU | Per-lane request ready |
| req_idx | input | NU*IW | Per-lane pointer index, lane 0 in the low bits |
| req_mode | input | NU*3 | Per-lane mode code |
| req_upd | input | NU | Per-lane write-back enable for modes 0 to 2 |
| addr_valid | output | NU | Per-lane address valid |
| addr_ready | input | NU | Per-lane address ready from the consumer |
| addr_data | output | NU*AW | Per-lane effective address |

## Verification
The bench builds the block with its defaults: 16-bit addresses, eight pointer entries, two lanes and a stack pointer starting at 0x1000. Sixteen address bits leave room for several aligned buffers in different regions. Eight entries allow linear, circular and reverse-carry streams with their own steps, and 8- and 16-point bit-reversed walks, without any reload between them. Circular lengths of 5, 6 and 12 exercise the wrap to a base below the power-of-two boundary, with both positive and negative steps. Two lanes bring the same-cycle read-before-write behaviour and the lower-lane-wins rule within reach.

// File: rtl/agu_pkg.sv
package agu_pkg;

  typedef enum logic [2:0] {
    AM_LIN  = 3'd0,
    AM_CIRC = 3'd1,
    AM_REV  = 3'd2,
    AM_PUSH = 3'd3,
    AM_POP  = 3'd4
  } amode_e;

  typedef enum logic [1:0] {
    CF_PTR  = 2'd0,
    CF_STEP = 2'd1,
    CF_MOD  = 2'd2,
    CF_SP   = 2'd3
  } cfile_e;

endpackage

// File: rtl/agu_aau.sv
module agu_aau
  import agu_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic [2:0]    mode,
  input  logic          upd,
  input  logic [AW-1:0] areg,
  input  logic [AW-1:0] step,
  input  logic [AW-1:0] modv,
  input  logic [AW-1:0] sp,
  output logic [AW-1:0] eff,
  output logic          ar_we,
  output logic [AW-1:0] ar_new,
  output logic          sp_we,
  output logic [AW-1:0] sp_new
);

  function automatic logic [AW-1:0] bitrev(input logic [AW-1:0] x);
    logic [AW-1:0] r;
    for (int k = 0; k < AW; k++) r[k] = x[AW-1-k];
    return r;
  endfunction

  // fill every bit below the highest set bit
  function automatic logic [AW-1:0] smear(input logic [AW-1:0] x);
    logic [AW-1:0] r;
    r = x;
    for (int k = 1; k < AW; k = k * 2) r = r | (r >> k);
    return r;
  endfunction

  logic [AW-1:0]        mmask, moff, mbase, circ_new, rev_new;
  logic signed [AW+1:0] msum, mfix, mlen;
  logic [1:0]           unused_hi;

  always_comb begin
    mmask = smear(modv - 1'b1);
    moff  = areg & mmask;
    mbase = areg & ~mmask;
    mlen  = $signed({2'b00, modv});
    msum  = $signed({2'b00, moff}) + $signed({{2{step[AW-1]}}, step});
    if (msum < 0)          mfix = msum + mlen;
    else if (msum >= mlen) mfix = msum - mlen;
    else                   mfix = msum;
    circ_new = (modv == '0) ? areg + step : (mbase | mfix[AW-1:0]);
    rev_new  = bitrev(bitrev(areg) + bitrev(step));
  end

  assign unused_hi = mfix[AW+1:AW];

  always_comb begin
    eff    = areg;
    ar_we  = 1'b0;
    ar_new = areg;
    sp_we  = 1'b0;
    sp_new = sp;
    case (amode_e'(mode))
      AM_CIRC: begin ar_we = upd; ar_new = circ_new; end
      AM_REV:  begin ar_we = upd; ar_new = rev_new;  end
      AM_PUSH: begin eff = sp - 1'b1; sp_we = 1'b1; sp_new = sp - 1'b1; end
      AM_POP:  begin eff = sp;        sp_we = 1'b1; sp_new = sp + 1'b1; end
      default: begin ar_we = upd; ar_new = areg + step; end
    endcase
  end

endmodule

// File: rtl/agu_regfile.sv
module agu_regfile
  import agu_pkg::*;
#(
  parameter int            AW      = 16,
  parameter int            NREG    = 8,
  parameter int            NU      = 2,
  parameter int            IW      = 3,
  parameter logic [AW-1:0] SP_INIT = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_file,
  input  logic [IW-1:0]    cfg_idx,
  input  logic [AW-1:0]    cfg_data,
  input  logic [NU-1:0]    u_we,
  input  logic [NU*IW-1:0] u_idx,
  input  logic [NU*AW-1:0] u_data,
  input  logic [NU-1:0]    s_we,
  input  logic [NU*AW-1:0] s_data,
  output logic [AW-1:0]    ar_q [NREG],
  output logic [AW-1:0]    st_q [NREG],
  output logic [AW-1:0]    md_q [NREG],
  output logic [AW-1:0]    sp_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) begin
        ar_q[i] <= '0;
        st_q[i] <= '0;
        md_q[i] <= '0;
      end
      sp_q <= SP_INIT;
    end else begin
      // highest lane first so lane 0 is assigned last and wins
      for (int u = NU - 1; u >= 0; u--) begin
        if (u_we[u]) ar_q[u_idx[u*IW +: IW]] <= u_data[u*AW +: AW];
        if (s_we[u]) sp_q <= s_data[u*AW +: AW];
      end
      if (cfg_we) begin
        case (cfile_e'(cfg_file))
          CF_PTR:  ar_q[cfg_idx] <= cfg_data;
          CF_STEP: st_q[cfg_idx] <= cfg_data;
          CF_MOD:  md_q[cfg_idx] <= cfg_data;
          default: sp_q          <= cfg_data;
        endcase
      end
    end
  end

endmodule

// File: rtl/agu_ostage.sv
module agu_ostage #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [AW-1:0] in_addr,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [AW-1:0] out_addr
);

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_addr  <= '0;
    end else if (in_valid && in_ready) begin
      out_valid <= 1'b1;
      out_addr  <= in_addr;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/dsp_agu.sv
module dsp_agu #(
  parameter int            AW      = 16,
  parameter int            NREG    = 8,
  parameter int            NU      = 2,
  parameter logic [AW-1:0] SP_INIT = 16'h1000,
  localparam int           IW      = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_file,
  input  logic [IW-1:0]    cfg_idx,
  input  logic [AW-1:0]    cfg_data,
  input  logic [NU-1:0]    req_valid,
  output logic [NU-1:0]    req_ready,
  input  logic [NU*IW-1:0] req_idx,
  input  logic [NU*3-1:0]  req_mode,
  input  logic [NU-1:0]    req_upd,
  output logic [NU-1:0]    addr_valid,
  input  logic [NU-1:0]    addr_ready,
  output logic [NU*AW-1:0] addr_data
);

  logic [AW-1:0]    ar_q [NREG];
  logic [AW-1:0]    st_q [NREG];
  logic [AW-1:0]    md_q [NREG];
  logic [AW-1:0]    sp_q;
  logic [NU-1:0]    u_we, s_we;
  logic [NU*AW-1:0] u_data, s_data;

  agu_regfile #(
    .AW(AW), .NREG(NREG), .NU(NU), .IW(IW), .SP_INIT(SP_INIT)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_file(cfg_file), .cfg_idx(cfg_idx), .cfg_data(cfg_data),
    .u_we(u_we), .u_idx(req_idx), .u_data(u_data),
    .s_we(s_we), .s_data(s_data),
    .ar_q(ar_q), .st_q(st_q), .md_q(md_q), .sp_q(sp_q)
  );

  for (genvar u = 0; u < NU; u++) begin : g_lane
    logic [IW-1:0] idx;
    logic [AW-1:0] eff, ar_new, sp_new;
    logic          ar_we, sp_we, acc;

    assign idx = req_idx[u*IW +: IW];
    assign acc = req_valid[u] && req_ready[u];

    agu_aau #(.AW(AW)) u_aau (
      .mode(req_mode[u*3 +: 3]), .upd(req_upd[u]),
      .areg(ar_q[idx]), .step(st_q[idx]), .modv(md_q[idx]), .sp(sp_q),
      .eff(eff), .ar_we(ar_we), .ar_new(ar_new), .sp_we(sp_we), .sp_new(sp_new)
    );

    assign u_we[u]              = acc && ar_we;
    assign u_data[u*AW +: AW]   = ar_new;
    assign s_we[u]              = acc && sp_we;
    assign s_data[u*AW +: AW]   = sp_new;

    agu_ostage #(.AW(AW)) u_out (
      .clk(clk), .rst_n(rst_n),
      .in_valid(req_valid[u]), .in_ready(req_ready[u]), .in_addr(eff),
      .out_valid(addr_valid[u]), .out_ready(addr_ready[u]),
      .out_addr(addr_data[u*AW +: AW])
    );
  end

endmodule

// File: rtl/agu_chk.sv
module agu_chk #(
  parameter int AW = 16,
  parameter int NU = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NU-1:0]    req_valid,
  input logic [NU-1:0]    req_ready,
  input logic [NU*3-1:0]  req_mode,
  input logic [NU-1:0]    addr_valid,
  input logic [NU-1:0]    addr_ready,
  input logic [NU*AW-1:0] addr_data,
  input logic             cfg_we,
  input logic [1:0]       cfg_file,
  input logic [AW-1:0]    sp_q
);

  for (genvar u = 0; u < NU; u++) begin : g_lane_chk
    // R9
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_valid[u] && !addr_ready[u]) |=> (addr_valid[u] && $stable(addr_data[u*AW +: AW])));

    // R9
    accept_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid[u] && req_ready[u]) |=> addr_valid[u]);
  end

  // R6
  push_sp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid[0] && req_ready[0] && req_mode[2:0] == 3'd3 && !(cfg_we && cfg_file == 2'd3))
      |=> (addr_data[AW-1:0] == sp_q));

  // R6
  pop_sp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid[0] && req_ready[0] && req_mode[2:0] == 3'd4 && !(cfg_we && cfg_file == 2'd3))
      |=> (sp_q == addr_data[AW-1:0] + {{(AW-1){1'b0}}, 1'b1}));

endmodule

bind dsp_agu agu_chk #(.AW(AW), .NU(NU)) u_agu_chk (
  .clk(clk), .rst_n(rst_n),
  .req_valid(req_valid), .req_ready(req_ready), .req_mode(req_mode),
  .addr_valid(addr_valid), .addr_ready(addr_ready), .addr_data(addr_data),
  .cfg_we(cfg_we), .cfg_file(cfg_file), .sp_q(sp_q)
);

// File: tb/test_dsp_agu.sv
`timescale 1ns/1ps
module test_dsp_agu;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_file = '0;
  logic [2:0]  cfg_idx = '0;
  logic [15:0] cfg_data = '0;
  logic [1:0]  req_valid = '0;
  logic [1:0]  req_ready;
  logic [5:0]  req_idx = '0;
  logic [5:0]  req_mode = '0;
  logic [1:0]  req_upd = '0;
  logic [1:0]  addr_valid;
  logic [1:0]  addr_ready = 2'b11;
  logic [31:0] addr_data;

  int checks = 0;
  int errors = 0;
  bit bp_on = 1'b0;
  int cyc = 0;

  logic [15:0] mA [8];
  logic [15:0] mN [8];
  logic [15:0] mM [8];
  logic [15:0] mSP = 16'h1000;

  logic [15:0] q0 [$];
  logic [15:0] q1 [$];
  string       t0 [$];
  string       t1 [$];

  always #2 clk = ~clk;

  dsp_agu i_dsp_agu (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_file(cfg_file), .cfg_idx(cfg_idx), .cfg_data(cfg_data),
    .req_valid(req_valid), .req_ready(req_ready), .req_idx(req_idx),
    .req_mode(req_mode), .req_upd(req_upd),
    .addr_valid(addr_valid), .addr_ready(addr_ready), .addr_data(addr_data)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] rev16(input logic [15:0] x);
    logic [15:0] r;
    for (int k = 0; k < 16; k++) r[k] = x[15-k];
    return r;
  endfunction

  function automatic logic [15:0] circ_next(input logic [15:0] a, input logic [15:0] n,
                                            input logic [15:0] m);
    int p, base, off, t;
    if (m == 0) return a + n;
    p = 1;
    while (p < int'(m)) p = p * 2;
    base = int'(a) & ~(p - 1);
    off  = int'(a) - base;
    t    = off + int'($signed(n));
    if (t < 0) t = t + int'(m);
    else if (t >= int'(m)) t = t - int'(m);
    return 16'(base + t);
  endfunction

  function automatic void calc(input int md, input int i, input bit up,
                               output logic [15:0] e, output bit aw, output logic [15:0] na,
                               output bit sw, output logic [15:0] ns);
    e = mA[i]; aw = 1'b0; na = mA[i]; sw = 1'b0; ns = mSP;
    case (md)
      1: begin aw = up; na = circ_next(mA[i], mN[i], mM[i]); end
      2: begin aw = up; na = rev16(rev16(mA[i]) + rev16(mN[i])); end
      3: begin e = mSP - 16'd1; sw = 1'b1; ns = mSP - 16'd1; end
      4: begin e = mSP; sw = 1'b1; ns = mSP + 16'd1; end
      default: begin aw = up; na = mA[i] + mN[i]; end
    endcase
  endfunction

  function automatic void model_cfg(input int f, input int i, input logic [15:0] d);
    case (f)
      0: mA[i] = d;
      1: mN[i] = d;
      2: mM[i] = d;
      default: mSP = d;
    endcase
  endfunction

  task automatic cfg(input int f, input int i, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_file = 2'(f); cfg_idx = 3'(i); cfg_data = d;
    @(posedge clk);
    #1;
    cfg_we = 1'b0;
    model_cfg(f, i, d);
  endtask

  // arm a configuration write that lands with the next issue
  task automatic cfg_arm(input int f, input int i, input logic [15:0] d);
    cfg_we = 1'b1; cfg_file = 2'(f); cfg_idx = 3'(i); cfg_data = d;
  endtask

  task automatic issue(input bit v0, input int i0, input int m0, input bit u0,
                       input bit v1, input int i1, input int m1, input bit u1,
                       input string tag);
    logic [15:0] e0, e1, na0, na1, ns0, ns1;
    bit aw0, aw1, sw0, sw1;
    @(negedge clk);
    req_valid = {v1, v0};
    req_idx   = {3'(i1), 3'(i0)};
    req_mode  = {3'(m1), 3'(m0)};
    req_upd   = {u1, u0};
    #1;
    while ((req_valid & req_ready) != req_valid) begin
      @(negedge clk);
      #1;
    end
    calc(m0, i0, u0, e0, aw0, na0, sw0, ns0);
    calc(m1, i1, u1, e1, aw1, na1, sw1, ns1);
    if (v0) begin q0.push_back(e0); t0.push_back(tag); end
    if (v1) begin q1.push_back(e1); t1.push_back(tag); end
    if (v1 && aw1) mA[i1] = na1;
    if (v1 && sw1) mSP = ns1;
    if (v0 && aw0) mA[i0] = na0;
    if (v0 && sw0) mSP = ns0;
    @(posedge clk);
    #1;
    req_valid = '0;
    if (cfg_we) begin
      model_cfg(int'(cfg_file), int'(cfg_idx), cfg_data);
      cfg_we = 1'b0;
    end
  endtask

  task automatic one(input int u, input int i, input int m, input bit up, input string tag);
    if (u == 0) issue(1'b1, i, m, up, 1'b0, 0, 0, 1'b0, tag);
    else        issue(1'b0, 0, 0, 1'b0, 1'b1, i, m, up, tag);
  endtask

  // consumer readiness
  initial forever begin
    @(negedge clk);
    cyc++;
    addr_ready = bp_on ? {1'b1, (cyc % 4 == 3)} : 2'b11;
  end

  // monitor: scoreboard compare of each transfer
  initial forever begin
    @(negedge clk);
    #2;
    if (rst_n) begin
      for (int u = 0; u < 2; u++) begin
        if (addr_valid[u] && !addr_ready[u])
          chk("R9 ready low under stall", 16'(req_ready[u]), 16'd0);
        if (addr_valid[u] && addr_ready[u]) begin
          if (u == 0) begin
            if (q0.size() == 0) chk("R9 unexpected lane0 output", addr_data[15:0], 16'hxxxx);
            else chk(t0.pop_front(), addr_data[15:0], q0.pop_front());
          end else begin
            if (q1.size() == 0) chk("R9 unexpected lane1 output", addr_data[31:16], 16'hxxxx);
            else chk(t1.pop_front(), addr_data[31:16], q1.pop_front());
          end
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R9: actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) begin mA[i] = '0; mN[i] = '0; mM[i] = '0; end
    repeat (3) @(negedge clk);
    chk("R1 req_ready in reset", 16'(req_ready), 16'h3);
    chk("R1 addr_valid in reset", 16'(addr_valid), 16'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 req_ready after reset", 16'(req_ready), 16'h3);
    chk("R1 addr_valid after reset", 16'(addr_valid), 16'h0);
    one(0, 0, 3, 1'b1, "R1 first push");
    one(0, 0, 4, 1'b1, "R6 pop back");

    // R2 linear
    cfg(0, 0, 16'h0100); cfg(1, 0, 16'd3);
    repeat (3) one(0, 0, 0, 1'b1, "R2 linear +3");
    cfg(0, 1, 16'h0050); cfg(1, 1, 16'hFFFE);
    repeat (3) one(1, 1, 0, 1'b1, "R2 linear -2");
    cfg(1, 1, 16'd1);
    one(1, 1, 6, 1'b1, "R2 code 6 linear");
    one(1, 1, 0, 1'b0, "R2 code 6 result");

    // R3 no write-back
    one(0, 0, 0, 1'b0, "R3 hold linear");
    one(0, 0, 1, 1'b0, "R3 hold circular");
    one(0, 0, 2, 1'b0, "R3 hold reverse");
    one(0, 0, 0, 1'b1, "R3 still there");

    // R4 circular, lengths 5, 6, 12, negative step, zero modifier
    cfg(0, 2, 16'h0200); cfg(1, 2, 16'd2); cfg(2, 2, 16'd5);
    repeat (7) one(0, 2, 1, 1'b1, "R4 len5 step2");
    cfg(0, 3, 16'h030A); cfg(1, 3, 16'd4); cfg(2, 3, 16'd6);
    repeat (5) one(1, 3, 1, 1'b1, "R4 len6 step4");
    cfg(0, 4, 16'h0601); cfg(1, 4, 16'hFFFD); cfg(2, 4, 16'd5);
    repeat (6) one(0, 4, 1, 1'b1, "R4 len5 step-3");
    cfg(0, 5, 16'h0700); cfg(1, 5, 16'd5); cfg(2, 5, 16'd12);
    repeat (8) one(0, 5, 1, 1'b1, "R4 len12 step5");
    cfg(0, 6, 16'h0040); cfg(1, 6, 16'd2); cfg(2, 6, 16'd0);
    repeat (2) one(0, 6, 1, 1'b1, "R4 zero modifier linear");

    // R5 bit-reversed walks of 8 and 16 points
    cfg(0, 7, 16'h0400); cfg(1, 7, 16'd4);
    repeat (9) one(0, 7, 2, 1'b1, "R5 fft8");
    cfg(0, 7, 16'h0800); cfg(1, 7, 16'd8);
    repeat (17) one(1, 7, 2, 1'b1, "R5 fft16");

    // R6 stack
    cfg(3, 0, 16'h0F00);
    one(0, 0, 3, 1'b0, "R6 push ignores upd");
    one(1, 0, 3, 1'b1, "R6 push lane1");
    one(0, 0, 4, 1'b1, "R6 pop");
    one(1, 0, 4, 1'b0, "R6 pop ignores upd");
    one(0, 0, 4, 1'b1, "R6 pop above base");

    // R7 parallel lanes
    cfg(0, 0, 16'h0010); cfg(1, 0, 16'd1);
    cfg(0, 1, 16'h0020); cfg(1, 1, 16'd1);
    repeat (3) issue(1'b1, 0, 0, 1'b1, 1'b1, 1, 0, 1'b1, "R7 dual linear");
    issue(1'b1, 0, 3, 1'b1, 1'b1, 0, 3, 1'b1, "R7 dual push same SP");
    one(0, 0, 4, 1'b1, "R8 single decrement kept");

    // R8 conflicting write-back
    cfg(0, 2, 16'h0103); cfg(1, 2, 16'd1); cfg(2, 2, 16'd0);
    issue(1'b1, 2, 0, 1'b1, 1'b1, 2, 2, 1'b1, "R8 lane0 linear vs lane1 rev");
    one(0, 2, 0, 1'b0, "R8 lane0 value kept");
    cfg(0, 2, 16'h0103);
    issue(1'b1, 2, 2, 1'b1, 1'b1, 2, 0, 1'b1, "R8 lane0 rev vs lane1 linear");
    one(1, 2, 0, 1'b0, "R8 lane0 rev kept");

    // R10 configuration write beats lane update
    cfg_arm(0, 2, 16'h0555);
    one(0, 2, 0, 1'b1, "R10 update under cfg");
    one(0, 2, 0, 1'b0, "R10 cfg value kept");
    cfg_arm(3, 0, 16'h0800);
    one(0, 0, 3, 1'b1, "R10 push under cfg");
    one(0, 0, 4, 1'b1, "R10 sp from cfg");

    // R9 back-pressure on lane 0
    cfg(0, 0, 16'h0A00); cfg(1, 0, 16'd2);
    bp_on = 1'b1;
    repeat (8) one(0, 0, 0, 1'b1, "R9 stalled stream");
    repeat (12) @(negedge clk);
    bp_on = 1'b0;
    one(0, 0, 0, 1'b0, "R9 no update while stalled");

    repeat (10) @(negedge clk);
    chk("R9 lane0 queue drained", 16'(q0.size()), 16'd0);
    chk("R9 lane1 queue drained", 16'(q1.size()), 16'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule